// File: doc/BRIEF.md
# Synchronous Serial Character Receiver with Hex Display

This block receives 7-bit characters sent over a three-wire synchronous link: a data line, a clock line driven by the far-end sender, and ground. Both link lines are plain logic inputs. They are brought into the local system clock domain through a flop chain. The data line is sampled once on each rising edge of the link clock.

The link has no framing or select line. The block therefore finds character boundaries on its own. It counts link clock edges, and it drops a partly received character if the link clock stays still for longer than a set number of system clocks. Each time a full character is assembled, the block latches it and emits a single-cycle received pulse. It also shows the value on two seven-segment digits in hexadecimal. The upper digit shows the three high bits and the lower digit shows the low nibble.

The block is intended for button-triggered traffic, where characters arrive as isolated bursts separated by long quiet periods.

Top module: `hexlink_rx`

## Requirements
- R1: After reset, `char_o` is 0, `rcvd_o` is low, and both digits show the glyph for 0 (7'h3F).
- R2: Data is sampled only on rising edges of the link clock, with the most significant bit first. Falling link clock edges do not advance reception.
- R3: When the seventh bit of a character is sampled, `rcvd_o` is high for exactly one system clock. In that same cycle `char_o` presents the assembled 7-bit value.
- R4: Between completions, `char_o` and both digits hold the last complete character. A partly received character has no effect on them.
- R5: If the link clock shows no rising edge for `IDLE_CYC` system clocks while a character is partly received, the partial bits are discarded. The next rising edge then starts a new character.
- R6: A pause in the link clock shorter than `IDLE_CYC` system clocks in the middle of a character does not discard the bits already received.
- R7: `seg_lo_o` shows `char_o[3:0]` and `seg_hi_o` shows {0, `char_o[6:4]`}. Segments are active high, with bit 0 = a through bit 6 = g. The glyphs are 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F, A=77, b=7C, C=39, d=5E, E=79, F=71 (hex).
- R8: Characters sent back to back with no idle gap are each received in turn, and each produces its own pulse.
- R9: Changes on the data line while the link clock is steady, whether high or low, do not affect the received value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Local system clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lnk_clk_i | input | 1 | Link clock from the sender |
| lnk_dat_i | input | 1 | Link serial data |
| seg_hi_o | output | 7 | Upper digit segments a..g (bit 0 = a) |
| seg_lo_o | output | 7 | Lower digit segments a..g (bit 0 = a) |
| char_o | output | 7 | Last complete received character |
| rcvd_o | output | 1 | One-cycle pulse on each completed character |

## Verification
The bench toggles the data line while the link clock is steady, and after every rising link clock edge. A receiver that sampled on the wrong edge, or sampled the data line continuously, would then capture inverted bits.

It stalls the link part-way through a character, once beyond the timeout and once well short of it. A missing timeout would blend stale bits into the next value. A timeout that is too eager would split a legitimate character.

Back-to-back characters check that the bit count wraps cleanly. Values with zero, full and mixed nibbles check the split of the upper and lower digits and every glyph pattern. A stretched or doubled received pulse is caught by watching for it on consecutive cycles.

// File: rtl/hexlink_pkg.sv
package hexlink_pkg;

  localparam int unsigned CHAR_W = 7;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned SEG_W  = 7;
  localparam int unsigned CNT_W  = $clog2(CHAR_W);

  typedef logic [CHAR_W-1:0] char_t;
  typedef logic [SEG_W-1:0]  seg_t;
  typedef logic [NIB_W-1:0]  nib_t;

  // Segment bit 0 = a ... bit 6 = g, active high.
  function automatic seg_t hex_glyph(input nib_t v);
    seg_t s;
    case (v)
      4'h0: s = 7'h3F;
      4'h1: s = 7'h06;
      4'h2: s = 7'h5B;
      4'h3: s = 7'h4F;
      4'h4: s = 7'h66;
      4'h5: s = 7'h6D;
      4'h6: s = 7'h7D;
      4'h7: s = 7'h07;
      4'h8: s = 7'h7F;
      4'h9: s = 7'h6F;
      4'hA: s = 7'h77;
      4'hB: s = 7'h7C;
      4'hC: s = 7'h39;
      4'hD: s = 7'h5E;
      4'hE: s = 7'h79;
      default: s = 7'h71;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/hexlink_rst_sync.sv
module hexlink_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/hexlink_sync.sv
module hexlink_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/hexlink_deser.sv
module hexlink_deser
  import hexlink_pkg::*;
#(
  parameter int unsigned IDLE_CYC = 1024
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  lclk_i,
  input  logic  ldat_i,
  output char_t char_o,
  output logic  done_o
);

  localparam int unsigned IDLE_W = $clog2(IDLE_CYC + 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_CYC - 1);
  localparam logic [CNT_W-1:0]  BIT_LAST  = CNT_W'(CHAR_W - 1);

  logic                lclk_prev_q;
  logic [CHAR_W-2:0]   shreg_q, shreg_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [IDLE_W-1:0]   idle_q, idle_d;
  char_t               char_q, char_d;
  logic                done_q, done_d;
  logic                rise;
  logic                partial;
  logic                idle_exp;

  assign rise     = lclk_i & ~lclk_prev_q;
  assign partial  = (cnt_q != '0);
  assign idle_exp = partial && !rise && (idle_q == IDLE_LAST);

  always_comb begin
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    idle_d  = idle_q;
    char_d  = char_q;
    done_d  = 1'b0;
    if (rise) begin
      idle_d  = '0;
      shreg_d = {shreg_q[CHAR_W-3:0], ldat_i};
      if (cnt_q == BIT_LAST) begin
        char_d = {shreg_q, ldat_i};
        done_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (idle_exp) begin
      cnt_d   = '0;
      idle_d  = '0;
      shreg_d = '0;
    end else if (partial) begin
      idle_d = idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lclk_prev_q <= 1'b0;
      shreg_q     <= '0;
      cnt_q       <= '0;
      idle_q      <= '0;
      char_q      <= '0;
      done_q      <= 1'b0;
    end else begin
      lclk_prev_q <= lclk_i;
      shreg_q     <= shreg_d;
      cnt_q       <= cnt_d;
      idle_q      <= idle_d;
      if (done_d) char_q <= char_d;
      done_q      <= done_d;
    end
  end

  assign char_o = char_q;
  assign done_o = done_q;

  // R3
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R4
  char_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(char_q) |-> done_q);

  // R5
  idle_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (partial && !rise && idle_q == IDLE_LAST) |=> (cnt_q == '0));

  // R2
  bit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= BIT_LAST);

  // R6
  no_early_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (partial && !rise && idle_q != IDLE_LAST) |=> (cnt_q != '0));

endmodule

// File: rtl/hexlink_seg.sv
module hexlink_seg
  import hexlink_pkg::*;
(
  input  nib_t nib_i,
  output seg_t seg_o
);

  always_comb begin
    seg_o = hex_glyph(nib_i);
    // R7
    seg_nonblank_chk: assert (seg_o != '0);
  end

endmodule

// File: rtl/hexlink_rx.sv
module hexlink_rx
  import hexlink_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IDLE_CYC    = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lnk_clk_i,
  input  logic       lnk_dat_i,
  output logic [6:0] seg_hi_o,
  output logic [6:0] seg_lo_o,
  output logic [6:0] char_o,
  output logic       rcvd_o
);

  localparam int unsigned DIGITS = 2;

  logic       rst_n;
  logic [1:0] lnk_s;
  char_t      char_w;
  logic       done_w;
  nib_t [DIGITS-1:0] nib_w;
  seg_t [DIGITS-1:0] seg_w;

  hexlink_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  hexlink_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .d_i    ({lnk_clk_i, lnk_dat_i}),
    .q_o    (lnk_s)
  );

  hexlink_deser #(.IDLE_CYC(IDLE_CYC)) u_deser (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .lclk_i (lnk_s[1]),
    .ldat_i (lnk_s[0]),
    .char_o (char_w),
    .done_o (done_w)
  );

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    if (d == 0) begin : g_lo
      assign nib_w[d] = char_w[NIB_W-1:0];
    end else begin : g_hi
      assign nib_w[d] = {1'b0, char_w[CHAR_W-1:NIB_W]};
    end
    hexlink_seg u_seg (
      .nib_i (nib_w[d]),
      .seg_o (seg_w[d])
    );
  end

  assign seg_lo_o = seg_w[0];
  assign seg_hi_o = seg_w[1];
  assign char_o   = char_w;
  assign rcvd_o   = done_w;

endmodule

// File: tb/hexlink_rx_tb.sv
module hexlink_rx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int IDLE       = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lclk = 1'b0;
  logic       ldat = 1'b0;
  logic [6:0] seg_hi, seg_lo, chr;
  logic       rcvd;

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  int doubles = 0;
  logic prev_rcvd = 1'b0;
  logic [6:0] last_cap = '0;
  logic [6:0] prev_cap = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hexlink_rx u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .lnk_clk_i (lclk),
    .lnk_dat_i (ldat),
    .seg_hi_o  (seg_hi),
    .seg_lo_o  (seg_lo),
    .char_o    (chr),
    .rcvd_o    (rcvd)
  );

  always @(negedge clk) begin
    if (rcvd) begin
      pulses++;
      prev_cap = last_cap;
      last_cap = chr;
      if (prev_rcvd) doubles++;
    end
    prev_rcvd = rcvd;
  end

  function automatic logic [6:0] glyph(input logic [3:0] v);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return t[v];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); ldat = ~b;
    @(negedge clk); ldat = b;
    repeat (2) @(negedge clk);
    lclk = 1'b1;
    repeat (2) @(negedge clk);
    ldat = ~b;
    repeat (2) @(negedge clk);
    lclk = 1'b0;
  endtask

  task automatic send_bits(input logic [6:0] v, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) send_bit(v[i]);
  endtask

  task automatic check_char(input logic [6:0] v, input int p0, input string req);
    repeat (8) @(negedge clk);
    check(pulses == p0 + 1, {req, " pulse"}, pulses, p0 + 1);
    check(chr == v, {req, " char"}, chr, v);
    check(last_cap == v, {req, " captured at pulse"}, last_cap, v);
    check(seg_lo == glyph(v[3:0]), "R7 lower digit", seg_lo, glyph(v[3:0]));
    check(seg_hi == glyph({1'b0, v[6:4]}), "R7 upper digit", seg_hi, glyph({1'b0, v[6:4]}));
  endtask

  task automatic send_char(input logic [6:0] v, input string req);
    int p0;
    p0 = pulses;
    send_bits(v, 6, 0);
    check_char(v, p0, req);
  endtask

  initial begin
    int unsigned seed;
    int p0;
    logic [6:0] hold;
    seed = $urandom(32'd4242);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1
    check(chr == 7'h00, "R1 char", chr, 0);
    check(rcvd == 1'b0, "R1 pulse", rcvd, 0);
    check(seg_hi == 7'h3F, "R1 upper digit", seg_hi, 7'h3F);
    check(seg_lo == 7'h3F, "R1 lower digit", seg_lo, 7'h3F);

    // R2 R3 R9 directed values
    send_char(7'h5A, "R2");
    send_char(7'h7F, "R3");
    send_char(7'h00, "R9");
    send_char(7'h40, "R2");
    send_char(7'h2B, "R9");

    // R4 partial character leaves display; R5 timeout drops it
    hold = chr;
    p0 = pulses;
    send_bits(7'h15, 6, 3);
    repeat (4) @(negedge clk);
    check(chr == hold, "R4 hold during partial", chr, hold);
    check(pulses == p0, "R4 no pulse on partial", pulses, p0);
    repeat (IDLE + 100) @(negedge clk);
    check(chr == hold, "R4 hold after timeout", chr, hold);
    send_char(7'h33, "R5");

    // R6 short pause keeps partial bits
    p0 = pulses;
    send_bits(7'h6C, 6, 4);
    repeat (IDLE / 2) @(negedge clk);
    send_bits(7'h6C, 3, 0);
    check_char(7'h6C, p0, "R6");

    // R8 back to back
    p0 = pulses;
    send_bits(7'h12, 6, 0);
    send_bits(7'h34, 6, 0);
    repeat (8) @(negedge clk);
    check(pulses == p0 + 2, "R8 pulses", pulses, p0 + 2);
    check(prev_cap == 7'h12, "R8 first char", prev_cap, 7'h12);
    check(chr == 7'h34, "R8 second char", chr, 7'h34);

    // random characters with random gaps
    for (int n = 0; n < 24; n++) begin
      logic [6:0] v;
      v = 7'($urandom());
      send_char(v, "R2 random");
      repeat ($urandom_range(0, 40)) @(negedge clk);
    end

    check(doubles == 0, "R3 single cycle pulse", doubles, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule